// File: doc/BRIEF.md
# Programmable memory bank decoder

The decoder steers a physical address to one of six memory module sockets. Each socket holds either a small module (one 8 MB unit) or a large one (four units, 32 MB), or it is empty. The decoder returns a one-hot bank select, the byte offset inside the selected module, and a miss flag. Population and module size come in as static inputs.

Out of reset, every populated socket is mapped automatically. Modules are packed end to end from address zero in ascending socket order. Software can then rewrite an eight-entry table of end addresses, counted in 8 MB units. Writing entry k (1 to 6) moves socket k-1. Its start is the end value already held in entry k-1, or zero for socket 0. The socket keeps that start, latched at the time of the write, until it is written again. A write takes effect from the clock edge that captures it. The decode path from address to outputs is combinational.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset every socket is in automatic mode: populated sockets are enabled, and each one's base is the sum of the sizes of the populated sockets below it (small = 1 unit, large = 4 units, 1 unit = 8 MB).
- R2: A write of value E to entry k, 1 <= k <= 6, with socket k-1 populated, switches socket k-1 to programmed mode with base S*8 MB. S is 0 for k = 1, otherwise the value held in entry k-1 at the time of the write.
- R3: A programmed socket is enabled only when its written end E differs from its start S. A write with E equal to S disables the bank.
- R4: A write to entry k whose socket k-1 is empty leaves the whole mapping unchanged. The value is still stored and serves as the start for socket k. An empty socket is never enabled.
- R5: Writes to entries 0 and 7 change no mapping. Socket 0 starts at 0 whatever entry 0 holds.
- R6: A socket's base is captured when it is written. A later rewrite of the entry below it does not move it.
- R7: An enabled bank covers byte addresses from base up to, but not including, base plus module size. On a hit, bank_offset equals address minus base.
- R8: When enabled banks overlap, the highest-numbered socket that covers the address is selected.
- R9: When no enabled bank covers the address, miss is 1, bank_sel is all zero and bank_offset is zero. Otherwise miss is 0.
- R10: bank_sel has at most one bit set, where bit s selects socket s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| present | input | 6 | Socket populated, bit s for socket s (static) |
| big | input | 6 | Socket holds a 32 MB module instead of 8 MB (static) |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Table entry written (0 to 7) |
| cfg_end | input | 5 | End address in 8 MB units |
| addr | input | 32 | Byte address to decode |
| bank_sel | output | 6 | One-hot selected socket |
| bank_offset | output | 25 | Byte offset inside the selected module |
| miss | output | 1 | No enabled bank covers addr |

## Verification
The hardest case to reach is a socket whose start comes from a table entry written earlier. The case is sharpest when that entry was written while its own socket was empty, and when the resulting bank lands under a higher-priority one. The directed part reaches it in steps. It reconfigures with a four-socket population, writes the entry of an empty socket, and then programs the next socket so that it lands inside the range of an automatically placed, higher-numbered large module. Random table writes over random populations, mixed with lookups, then cover stale starts, zero-size banks and overlaps.

// File: rtl/mem_bank_decoder.sv
`timescale 1ns/1ps
module mem_bank_decoder #(
  parameter int NS          = 6,
  parameter int END_W       = 5,
  parameter int UNIT_LOG2   = 23,
  parameter int ADDR_W      = 32,
  parameter int SMALL_UNITS = 1,
  parameter int BIG_UNITS   = 4,
  localparam int IDX_W      = $clog2(NS + 2),
  localparam int OFS_W      = UNIT_LOG2 + $clog2(BIG_UNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     present,
  input  logic [NS-1:0]     big,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [END_W-1:0]  cfg_end,
  input  logic [ADDR_W-1:0] addr,
  output logic [NS-1:0]     bank_sel,
  output logic [OFS_W-1:0]  bank_offset,
  output logic              miss
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int UCW     = ADDR_W - UNIT_LOG2 + 1;
  localparam int HI_W    = OFS_W - UNIT_LOG2;

  logic [END_W-1:0]           end_tab [ENTRIES];
  logic [NS-1:0][END_W-1:0]   start_of;
  logic [NS-1:0][END_W-1:0]   base_q;
  logic [NS-1:0]              en_q, prog_q;
  logic [NS-1:0][UCW-1:0]     size_u, auto_base, map_base;
  logic [NS-1:0]              map_en, hit;
  logic [HI_W-1:0]            hi_u;

  wire [UCW-1:0] addr_w = {1'b0, addr[ADDR_W-1:UNIT_LOG2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) end_tab[e] <= '0;
      base_q <= '0;
      en_q   <= '0;
      prog_q <= '0;
    end else if (cfg_we) begin
      end_tab[cfg_idx] <= cfg_end;
      for (int s = 0; s < NS; s++) begin
        if (cfg_idx == IDX_W'(s + 1) && present[s]) begin
          prog_q[s] <= 1'b1;
          base_q[s] <= start_of[s];
          en_q[s]   <= (cfg_end != start_of[s]);
        end
      end
    end
  end

  always_comb begin
    logic [UCW-1:0] acc;
    acc = '0;
    for (int s = 0; s < NS; s++) begin
      auto_base[s] = acc;
      if (present[s]) acc = acc + size_u[s];
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_sock
    if (s == 0) begin : g_first
      assign start_of[s] = '0;
    end else begin : g_next
      assign start_of[s] = end_tab[s];
    end
    assign size_u[s]   = big[s] ? UCW'(BIG_UNITS) : UCW'(SMALL_UNITS);
    assign map_base[s] = prog_q[s] ? UCW'(base_q[s]) : auto_base[s];
    assign map_en[s]   = present[s] & (~prog_q[s] | en_q[s]);
    assign hit[s]      = map_en[s] && (addr_w >= map_base[s])
                         && (addr_w < map_base[s] + size_u[s]);
  end

  always_comb begin
    bank_sel = '0;
    hi_u     = '0;
    for (int s = 0; s < NS; s++) begin
      if (hit[s]) begin
        bank_sel    = '0;
        bank_sel[s] = 1'b1;
        hi_u        = HI_W'(addr_w - map_base[s]);
      end
    end
  end

  assign bank_offset = miss ? '0 : {hi_u, addr[UNIT_LOG2-1:0]};
  assign miss        = ~|hit;
endmodule

// File: rtl/mem_bank_decoder_chk.sv
`timescale 1ns/1ps
module mem_bank_decoder_chk #(
  parameter int NS    = 6,
  parameter int END_W = 5,
  parameter int IDX_W = 3,
  parameter int OFS_W = 25,
  parameter int UCW   = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NS-1:0]          present,
  input logic                   cfg_we,
  input logic [IDX_W-1:0]       cfg_idx,
  input logic [END_W-1:0]       cfg_end,
  input logic [NS-1:0]          bank_sel,
  input logic [OFS_W-1:0]       bank_offset,
  input logic                   miss,
  input logic [NS-1:0][UCW-1:0] map_base,
  input logic [NS-1:0]          map_en
);
  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R9
  miss_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss == (bank_sel == '0));

  // R9
  miss_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> bank_offset == '0);

  // R4
  empty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en & ~present) == '0);

  // R4
  empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_idx != '0 && cfg_idx <= IDX_W'(NS) && !present[cfg_idx - 1'b1]
    |=> $stable(map_base) && $stable(map_en));

  // R5
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_idx == '0 || cfg_idx == IDX_W'(NS + 1))
    |=> $stable(map_base) && $stable(map_en));

  // R2
  sock0_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_idx == IDX_W'(1) && present[0]
    |=> map_base[0] == '0 && map_en[0] == ($past(cfg_end) != '0));
endmodule

bind mem_bank_decoder mem_bank_decoder_chk #(
  .NS(NS), .END_W(END_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .UCW(UCW)
) u_chk (.*);

// File: tb/mem_bank_decoder_bench.sv
`timescale 1ns/1ps
module mem_bank_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  present = '0, big = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [4:0]  cfg_end = '0;
  logic [31:0] addr = '0;
  logic [5:0]  bank_sel;
  logic [24:0] bank_offset;
  logic        miss;

  int nchk = 0, nerr = 0;
  int m_tab [8];
  int m_base [6];
  bit m_en [6], m_prog [6];

  always #2.5 clk = ~clk;

  mem_bank_decoder u_mem_bank_decoder (.*);

  function automatic logic [31:0] at(input int u, input int off);
    return (32'(u) << 23) + 32'(off);
  endfunction

  function automatic void expect_dec(input logic [31:0] a, output logic [5:0] es,
                                     output logic [24:0] eo, output logic em);
    int acc, u, sz, b;
    bit en;
    acc = 0;
    u = int'(a >> 23);
    es = '0;
    eo = '0;
    for (int s = 0; s < 6; s++) begin
      sz = big[s] ? 4 : 1;
      b  = m_prog[s] ? m_base[s] : acc;
      en = present[s] && (!m_prog[s] || m_en[s]);
      if (en && u >= b && u < b + sz) begin
        es = 6'(1 << s);
        eo = 25'(a - (32'(b) << 23));
      end
      if (present[s]) acc += sz;
    end
    em = (es == '0);
  endfunction

  task automatic do_reset(input logic [5:0] p, input logic [5:0] b);
    @(negedge clk);
    rst_n = 1'b0;
    present = p;
    big = b;
    cfg_we = 1'b0;
    for (int i = 0; i < 8; i++) m_tab[i] = 0;
    for (int s = 0; s < 6; s++) begin
      m_base[s] = 0;
      m_en[s] = 1'b0;
      m_prog[s] = 1'b0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int idx, input int e);
    int st;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = 3'(idx);
    cfg_end = 5'(e);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx >= 1 && idx <= 6 && present[idx-1]) begin
      st = (idx == 1) ? 0 : m_tab[idx-1];
      m_prog[idx-1] = 1'b1;
      m_base[idx-1] = st;
      m_en[idx-1] = (e != st);
    end
    m_tab[idx] = e;
  endtask

  task automatic chk(input string tag, input logic [31:0] a);
    logic [5:0] es;
    logic [24:0] eo;
    logic em;
    @(negedge clk);
    addr = a;
    #1;
    expect_dec(a, es, eo, em);
    nchk++;
    if (bank_sel !== es || bank_offset !== eo || miss !== em) begin
      nerr++;
      $display("FAIL %s addr=%h sel=%b exp %b offset=%h exp %h miss=%b exp %b",
               tag, a, bank_sel, es, bank_offset, eo, miss, em);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // population A: all present, sockets 0,1 large -> bases 0,4,8,9,10,11
    do_reset(6'b111111, 6'b000011);
    chk("R1", at(0, 0));
    chk("R1", at(3, 32'h7f_ffff));
    chk("R1", at(4, 5));
    chk("R1", at(8, 0));
    chk("R1", at(11, 32'h12_3456));
    chk("R9", at(12, 0));
    chk("R9", 32'hffff_fff0);
    wr(1, 4);
    chk("R2", at(2, 77));
    wr(2, 8);
    chk("R2", at(4, 1));
    chk("R7", at(7, 32'h7f_ffff));
    wr(3, 8);
    chk("R3", at(8, 0));
    wr(0, 31);
    wr(7, 5);
    chk("R5", at(0, 9));
    chk("R5", at(9, 9));
    wr(1, 2);
    chk("R5", at(1, 3));
    chk("R6", at(4, 0));
    chk("R6", at(7, 100));
    wr(5, 3);
    chk("R8", at(0, 12));
    chk("R8", at(1, 12));
    // population B: sockets 0,2,3,5; 2 and 5 large -> bases 0,1,5,6
    do_reset(6'b101101, 6'b100100);
    chk("R1", at(1, 0));
    chk("R1", at(6, 4));
    chk("R9", at(10, 0));
    wr(2, 6);
    chk("R4", at(1, 0));
    chk("R4", at(5, 0));
    wr(3, 9);
    chk("R4", at(1, 0));
    chk("R8", at(6, 0));
    chk("R8", at(9, 32'h7f_ffff));
    // random populations, writes and lookups
    for (int r = 0; r < 6; r++) begin
      do_reset(6'($urandom), 6'($urandom));
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 3 == 0)
          wr(int'($urandom % 8), int'($urandom % 32));
        else if ($urandom % 10 == 0)
          chk("R7", $urandom);
        else
          chk("R7", at(int'($urandom % 40), int'($urandom % 32'h80_0000)));
      end
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule